// File: doc/BRIEF.md
# Double-Buffered DAC Code Register Front End

This block is the synchronous digital front end of a 12-bit multiplying DAC. All asynchronous strobes and the data bus are brought into the system clock through a two-flop synchroniser. A chip-select-qualified write strobe loads the data bus into a split input latch. The latch has an upper part (bits 11..8) and a lower part (bits 7..0), and a byte-steering control decides which parts accept the bus.

A separate enable/transfer strobe pair copies the complete input-latch word into the DAC code register. The register drives the code and its bitwise inverse, one for each of the two current-output buses. Because of this second stage, the converter output changes only once for each complete word, however many partial writes build that word.

A timing monitor in the clock domain checks that data is stable for a setup window before the end of a qualified write and for a hold window after it. On a breach it raises a sticky flag.

Top module: `dac_dbuf_if`

## Requirements
- R1: After reset, both input-latch parts and the code register are zero, `code_o` is 0, `code_n_o` is all ones and `viol_o` is 0.
- R2: A write strobe (`wr1_ni` low) while `cs_ni` is high leaves the input latch unchanged.
- R3: A qualified write with `byte_sel_i` high loads all 12 bus bits into the input latch.
- R4: A qualified write with `byte_sel_i` low loads bits 7..0 only; latch bits 11..8 keep their value.
- R5: A write changes `code_o` only after a transfer; the code register changes only on the end of a transfer.
- R6: A transfer takes place only when `wr2_ni` and `xfer_ni` are both low; either one alone has no effect.
- R7: `code_n_o` is always the bitwise inverse of `code_o`.
- R8: If data is not stable for `SETUP_CYC` synchronised cycles before a qualified write ends, `viol_o` is set.
- R9: If data changes within `HOLD_CYC` synchronised cycles after a qualified write ends, `viol_o` is set.
- R10: Once set, `viol_o` stays set until reset.
- R11: The latch captures at the end (rising edge) of the qualified write strobe, so a bus value that changes while the strobe is held low is replaced by the value present at its end. A held strobe produces one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; qualifies write-1 |
| wr1_ni | input | 1 | Input-latch write strobe, active low |
| byte_sel_i | input | 1 | 1: load all bits; 0: load bits 7..0 only |
| wr2_ni | input | 1 | Transfer enable, active low |
| xfer_ni | input | 1 | Transfer strobe, active low |
| data_i | input | 12 | Data bus, bit 0 is the LSB |
| code_o | output | 12 | DAC code register |
| code_n_o | output | 12 | Bitwise inverse of the code |
| viol_o | output | 1 | Sticky setup/hold violation flag |

## Verification
The assertions assume that every strobe and data level is held for at least a few clock cycles, so that the synchroniser passes each transition without loss. They also assume that byte select stays stable while a write is in progress. The stimulus changes inputs only on falling clock edges. It holds each strobe low for four cycles and keeps data and byte select steady for four cycles on either side of each write end. Only the directed violation cases break the data window, and they do so by exactly one cycle.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
  localparam int unsigned CTRL_W = 5;
  // control bit positions inside the synchroniser bus
  localparam int unsigned C_CS   = 0;
  localparam int unsigned C_WR1  = 1;
  localparam int unsigned C_WR2  = 2;
  localparam int unsigned C_XFER = 3;
  localparam int unsigned C_BYTE = 4;
  // active-low strobes idle high, byte select idles low
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 5'b01111;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/strobe_end_det.sv
module strobe_end_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic end_o
);
  logic act_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_i;
  end
  assign end_o = act_q & ~act_i;

  // a held strobe yields a single capture pulse
  assert_single_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);
endmodule

// File: rtl/sh_window_chk.sv
module sh_window_chk #(
  parameter int unsigned W = 12,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         wr_end_i,
  output logic         viol_o
);
  localparam int unsigned SW = $clog2(SETUP_CYC + 1) + 1;
  localparam int unsigned HW = $clog2(HOLD_CYC + 1) + 1;

  logic [W-1:0]  data_q;
  logic [SW-1:0] stab_q;
  logic [HW-1:0] hold_q;
  logic          viol_q;
  logic          chg, setup_bad, hold_bad;

  assign chg       = data_i != data_q;
  assign setup_bad = wr_end_i && (stab_q < SW'(SETUP_CYC));
  assign hold_bad  = chg && (wr_end_i || hold_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      stab_q <= '0;
      hold_q <= '0;
      viol_q <= 1'b0;
    end else begin
      data_q <= data_i;
      if (chg)                          stab_q <= '0;
      else if (stab_q < SW'(SETUP_CYC)) stab_q <= stab_q + 1'b1;
      if (wr_end_i)                     hold_q <= HW'(HOLD_CYC);
      else if (hold_q != '0)            hold_q <= hold_q - 1'b1;
      if (setup_bad || hold_bad)        viol_q <= 1'b1;
    end
  end
  assign viol_o = viol_q;

  assert_viol_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> viol_q);
  assert_setup_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_bad |=> viol_q);
  assert_hold_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_bad |=> viol_q);
endmodule

// File: rtl/dac_dbuf_if.sv
module dac_dbuf_if
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LSB_W = 8,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr1_ni,
  input  logic              byte_sel_i,
  input  logic              wr2_ni,
  input  logic              xfer_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] code_o,
  output logic [DATA_W-1:0] code_n_o,
  output logic              viol_o
);
  localparam int unsigned MSB_W = DATA_W - LSB_W;
  localparam int unsigned BUS_W = DATA_W + CTRL_W;
  localparam int unsigned N_STB = 2;

  logic [BUS_W-1:0]  raw_bus, syn_bus;
  logic [CTRL_W-1:0] ctl_s;
  logic [DATA_W-1:0] data_s;
  logic [N_STB-1:0]  stb_act, stb_end;
  logic              wr_end, xf_end;

  logic [MSB_W-1:0]  msb_q;
  logic [LSB_W-1:0]  lsb_q;
  logic [DATA_W-1:0] dac_q;

  assign raw_bus = {data_i, byte_sel_i, xfer_ni, wr2_ni, wr1_ni, cs_ni};

  sync_2ff #(.W(BUS_W), .RST_VAL({{DATA_W{1'b0}}, CTRL_IDLE})) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_bus),
    .q_o   (syn_bus)
  );
  assign ctl_s  = syn_bus[CTRL_W-1:0];
  assign data_s = syn_bus[BUS_W-1:CTRL_W];

  // strobe 0: qualified write-1, strobe 1: enabled transfer
  assign stb_act[0] = ~ctl_s[C_CS]  & ~ctl_s[C_WR1];
  assign stb_act[1] = ~ctl_s[C_WR2] & ~ctl_s[C_XFER];

  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    strobe_end_det u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .act_i (stb_act[g]),
      .end_o (stb_end[g])
    );
  end
  assign wr_end = stb_end[0];
  assign xf_end = stb_end[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q <= '0;
      lsb_q <= '0;
    end else if (wr_end) begin
      lsb_q <= data_s[LSB_W-1:0];
      if (ctl_s[C_BYTE]) msb_q <= data_s[DATA_W-1:LSB_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dac_q <= '0;
    else if (xf_end) dac_q <= {msb_q, lsb_q};
  end

  sh_window_chk #(.W(DATA_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_s),
    .wr_end_i(wr_end),
    .viol_o  (viol_o)
  );

  assign code_o   = dac_q;
  assign code_n_o = ~dac_q;

  assert_dac_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xf_end |=> $stable(dac_q));
  assert_lsb_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_end |=> $stable(lsb_q));
  assert_msb_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_end && ctl_s[C_BYTE]) |=> $stable(msb_q));
  assert_xfer_needs_both_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xf_end |-> $past(!ctl_s[C_WR2] && !ctl_s[C_XFER]));
  always_comb assert_inverse_R7: assert (code_n_o == ~code_o);
endmodule

// File: tb/tb_dac_dbuf_if.sv
module tb_dac_dbuf_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr1_n = 1'b1, byte_sel = 1'b0;
  logic        wr2_n = 1'b1, xfer_n = 1'b1;
  logic [11:0] data = '0;
  logic [11:0] code, code_n;
  logic        viol;

  int checks = 0, fails = 0;
  logic [11:0] m_latch = '0, m_dac = '0;

  always #2 clk = ~clk;

  dac_dbuf_if dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr1_ni(wr1_n),
    .byte_sel_i(byte_sel), .wr2_ni(wr2_n), .xfer_ni(xfer_n),
    .data_i(data), .code_o(code), .code_n_o(code_n), .viol_o(viol)
  );

  function automatic logic [11:0] f_write(logic [11:0] lat, logic [11:0] d, logic b, logic cs);
    if (cs) return lat;
    return b ? d : {lat[11:8], d[7:0]};
  endfunction

  task automatic chk(string req, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [11:0] d, logic b, logic cs);
    @(negedge clk);
    data = d; byte_sel = b; cs_n = cs; wr1_n = 1'b0;
    cyc(4); wr1_n = 1'b1;
    cyc(4); cs_n = 1'b1;
    cyc(2);
    m_latch = f_write(m_latch, d, b, cs);
  endtask

  task automatic do_xfer(logic w2, logic xf);
    @(negedge clk);
    wr2_n = w2; xfer_n = xf;
    cyc(4); wr2_n = 1'b1; xfer_n = 1'b1;
    cyc(6);
    if (!w2 && !xf) m_dac = m_latch;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(3);
    m_latch = '0; m_dac = '0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog got=%h exp=%h", 12'h0, 12'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    chk("R1", code, 12'h000);
    chk("R7", code_n, 12'hfff);
    chk("R1", {11'h0, viol}, 12'h0);
    do_xfer(1'b0, 1'b0);
    chk("R1", code, 12'h000);

    do_write(12'habc, 1'b1, 1'b0);
    chk("R5", code, 12'h000);             // not visible before transfer
    do_xfer(1'b0, 1'b0);
    chk("R3", code, 12'habc);
    chk("R7", code_n, ~12'habc);

    do_write(12'h512, 1'b0, 1'b0);
    do_xfer(1'b0, 1'b0);
    chk("R4", code, 12'ha12);

    do_write(12'h777, 1'b1, 1'b1);        // chip not selected
    do_xfer(1'b0, 1'b0);
    chk("R2", code, 12'ha12);

    do_write(12'h3c3, 1'b1, 1'b0);
    do_xfer(1'b1, 1'b0);
    chk("R6", code, 12'ha12);
    do_xfer(1'b0, 1'b1);
    chk("R6", code, 12'ha12);
    do_xfer(1'b0, 1'b0);
    chk("R6", code, 12'h3c3);

    // R11: bus changes while strobe held, value at end wins
    @(negedge clk);
    data = 12'h111; byte_sel = 1'b1; cs_n = 1'b0; wr1_n = 1'b0;
    cyc(2); data = 12'h9e5;
    cyc(4); wr1_n = 1'b1;
    cyc(4); cs_n = 1'b1; cyc(2);
    m_latch = 12'h9e5;
    do_xfer(1'b0, 1'b0);
    chk("R11", code, 12'h9e5);

    for (int i = 0; i < 60; i++) begin
      logic [11:0] d;
      logic b, c;
      d = 12'($urandom);
      b = 1'($urandom);
      c = ($urandom % 4) == 0;
      do_write(d, b, c);
      if ($urandom % 2) begin
        do_xfer(1'b0, 1'b0);
        chk(c ? "R2" : (b ? "R3" : "R4"), code, m_dac);
        chk("R7", code_n, ~m_dac);
      end
    end
    chk("R8", {11'h0, viol}, 12'h0);      // clean traffic leaves flag low

    // R8: data changes one cycle before write end
    @(negedge clk);
    data = 12'h0f0; byte_sel = 1'b1; cs_n = 1'b0; wr1_n = 1'b0;
    cyc(3); data = 12'h0f1;
    cyc(1); wr1_n = 1'b1;
    cyc(4); cs_n = 1'b1; cyc(4);
    chk("R8", {11'h0, viol}, 12'h1);

    do_reset();
    chk("R10", {11'h0, viol}, 12'h0);
    chk("R1", code, 12'h000);

    // R9: data changes one cycle after write end
    @(negedge clk);
    data = 12'h456; byte_sel = 1'b1; cs_n = 1'b0; wr1_n = 1'b0;
    cyc(4); wr1_n = 1'b1;
    cyc(1); data = 12'h457;
    cyc(4); cs_n = 1'b1; cyc(4);
    chk("R9", {11'h0, viol}, 12'h1);
    do_write(12'h222, 1'b1, 1'b0);
    do_xfer(1'b0, 1'b0);
    chk("R10", {11'h0, viol}, 12'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule